// File: doc/BRIEF.md
# UART DMA Request Pin Driver

This block produces the two active-low request lines, receive-ready and transmit-ready, that a UART channel presents to an external DMA controller. It observes the fill levels of the receive and transmit FIFOs, the programmed trigger thresholds, the receive time-out event, a host read strobe and the transmit shift-register empty flag. From these it decides when the controller should move data.

Two signalling styles exist. Single-transfer mode applies when the FIFOs are disabled, or when they are enabled with the block-transfer select bit clear. In that mode each request follows the presence or absence of data. Block-transfer mode applies when the FIFOs are enabled and the select bit is set. In that mode each request asserts at a programmed threshold and holds until its FIFO has been fully drained (receive) or fully filled (transmit). That way the controller moves whole bursts. Both outputs come from flops, so each one reflects the inputs of the previous clock.

Top module: `dma_ready_gen`

## Requirements
- R1: While rst_n is low, both rx_rdy_n and tx_rdy_n are high.
- R2: Block-transfer mode is in effect only when fifo_en and dma_block_sel are both 1. Every other combination gives single-transfer mode.
- R3: In single-transfer mode, rx_rdy_n is low exactly when rx_fill is 1 or more.
- R4: In single-transfer mode, tx_rdy_n is low exactly when tx_fill is 0 and tx_shift_empty is 1. Otherwise it is high.
- R5: A trigger code of 0 or 1 gives a threshold of 1. Codes 2 to 128 give a threshold equal to the code. Codes above 128 give a threshold of 128.
- R6: In block-transfer mode, rx_rdy_n goes low once rx_fill is greater than or equal to the receive threshold.
- R7: In block-transfer mode, a one-cycle rx_timeout pulse drives rx_rdy_n low whatever the fill level. The time-out stays remembered until a cycle with rx_pop high, and a time-out in the same cycle as rx_pop wins.
- R8: In block-transfer mode, once rx_rdy_n is low it stays low until rx_fill is 0 with no time-out pending. It then returns high.
- R9: In block-transfer mode, tx_rdy_n goes low when the free space (128 minus tx_fill) is greater than or equal to the transmit threshold.
- R10: In block-transfer mode, tx_rdy_n goes high when tx_fill reaches 128. It then stays high until the free space again meets the threshold.
- R11: Each output changes on the first rising clock edge after the input change that causes it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_block_sel | input | 1 | Selects block-transfer signalling when FIFOs are enabled |
| rx_trig_cfg | input | 8 | Receive trigger code |
| tx_trig_cfg | input | 8 | Transmit trigger code |
| rx_fill | input | 8 | Receive FIFO occupancy, 0 to 128 |
| tx_fill | input | 8 | Transmit FIFO occupancy, 0 to 128 |
| rx_timeout | input | 1 | One-cycle receive time-out event |
| rx_pop | input | 1 | Host read of the receive FIFO |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rx_rdy_n | output | 1 | Receive DMA request, active low |
| tx_rdy_n | output | 1 | Transmit DMA request, active low |

## Verification
The bench targets the hysteresis windows. It drains the receive FIFO to a level below the threshold and expects the request to stay asserted. A design that compares the fill level alone would release the request early. The bench also sits the transmit FIFO just under the threshold after it was full and expects the request to stay released; a level-only design would re-request at the wrong time. It drives the threshold edge codes 0, 1, 128 and 255, where a decoder that does not clamp would give thresholds of 0 or 255. It then pulses a time-out while the FIFO is empty and expects the request to hold until the next read; a design that does not remember the event would drop the pulse.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_BLOCK  = 1'b1
  } dma_sig_mode_e;

  function automatic dma_sig_mode_e pick_mode(input logic fifo_on, input logic blk_sel);
    return (fifo_on && blk_sel) ? MODE_BLOCK : MODE_SINGLE;
  endfunction
endpackage

// File: rtl/dma_trig_decode.sv
module dma_trig_decode #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 128
) (
  input  logic [CNT_W-1:0] code,
  output logic [CNT_W-1:0] thr
);
  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  always_comb begin
    if (code <= ONE_V)        thr = ONE_V;
    else if (code > DEPTH_V)  thr = DEPTH_V;
    else                      thr = code;
  end
endmodule

// File: rtl/dma_rx_req.sv
module dma_rx_req #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_mode,
  input  logic [CNT_W-1:0] thr,
  input  logic [CNT_W-1:0] fill,
  input  logic             tmo_evt,
  input  logic             pop,
  output logic             req_n
);
  logic tmo_q, tmo_d;
  logic req_n_q, req_n_d;
  logic tmo_live, reach, empty;

  always_comb begin
    tmo_live = tmo_q & ~pop;
    reach    = (fill >= thr);
    empty    = (fill == '0);
    tmo_d    = blk_mode & (tmo_evt | tmo_live);
    if (blk_mode) begin
      if (reach || tmo_evt || tmo_live) req_n_d = 1'b0;
      else if (empty)                   req_n_d = 1'b1;
      else                              req_n_d = req_n_q;
    end else begin
      req_n_d = empty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q   <= 1'b0;
      req_n_q <= 1'b1;
    end else begin
      tmo_q   <= tmo_d;
      req_n_q <= req_n_d;
    end
  end

  assign req_n = req_n_q;
endmodule

// File: rtl/dma_tx_req.sv
module dma_tx_req #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_mode,
  input  logic [CNT_W-1:0] thr,
  input  logic [CNT_W-1:0] fill,
  input  logic             shift_empty,
  output logic             req_n
);
  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

  logic req_n_q, req_n_d;
  logic [CNT_W-1:0] room;
  logic full, roomy;

  always_comb begin
    full  = (fill >= DEPTH_V);
    room  = full ? '0 : (DEPTH_V - fill);
    roomy = (room >= thr);
    if (blk_mode) begin
      if (full)       req_n_d = 1'b1;
      else if (roomy) req_n_d = 1'b0;
      else            req_n_d = req_n_q;
    end else begin
      req_n_d = !((fill == '0) && shift_empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_n_q <= 1'b1;
    else        req_n_q <= req_n_d;
  end

  assign req_n = req_n_q;
endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             dma_block_sel,
  input  logic [CNT_W-1:0] rx_trig_cfg,
  input  logic [CNT_W-1:0] tx_trig_cfg,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic [CNT_W-1:0] tx_fill,
  input  logic             rx_timeout,
  input  logic             rx_pop,
  input  logic             tx_shift_empty,
  output logic             rx_rdy_n,
  output logic             tx_rdy_n
);
  import dma_rdy_pkg::*;

  dma_sig_mode_e mode;
  logic          blk;
  logic [CNT_W-1:0] rx_thr, tx_thr;

  always_comb begin
    mode = pick_mode(fifo_en, dma_block_sel);
    blk  = (mode == MODE_BLOCK);
  end

  dma_trig_decode #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_rx_dec (
    .code(rx_trig_cfg), .thr(rx_thr)
  );

  dma_trig_decode #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_tx_dec (
    .code(tx_trig_cfg), .thr(tx_thr)
  );

  dma_rx_req #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk), .thr(rx_thr), .fill(rx_fill),
    .tmo_evt(rx_timeout), .pop(rx_pop), .req_n(rx_rdy_n)
  );

  dma_tx_req #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk), .thr(tx_thr), .fill(tx_fill),
    .shift_empty(tx_shift_empty), .req_n(tx_rdy_n)
  );
endmodule

// File: rtl/dma_ready_gen_chk.sv
module dma_ready_gen_chk #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             dma_block_sel,
  input logic [CNT_W-1:0] rx_fill,
  input logic [CNT_W-1:0] tx_fill,
  input logic             tx_shift_empty,
  input logic             rx_rdy_n,
  input logic             tx_rdy_n
);
  localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);
  logic blk;
  assign blk = fifo_en && dma_block_sel;

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (rx_rdy_n && tx_rdy_n));

  a_r3_single_rx_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk && rx_fill != '0) |=> !rx_rdy_n);

  a_r4_single_tx_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk && (tx_fill != '0 || !tx_shift_empty)) |=> tx_rdy_n);

  a_r6_block_rx_full: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && rx_fill == DEPTH_V) |=> !rx_rdy_n);

  a_r9_block_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && tx_fill == '0) |=> !tx_rdy_n);

  a_r10_block_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && tx_fill == DEPTH_V) |=> tx_rdy_n);
endmodule

bind dma_ready_gen dma_ready_gen_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_block_sel(dma_block_sel),
  .rx_fill(rx_fill), .tx_fill(tx_fill), .tx_shift_empty(tx_shift_empty),
  .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
);

// File: tb/dma_ready_gen_tb.sv
module dma_ready_gen_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk, rst_n, fifo_en, dma_block_sel;
  logic [7:0] rx_trig_cfg, tx_trig_cfg, rx_fill, tx_fill;
  logic       rx_timeout, rx_pop, tx_shift_empty;
  logic       rx_rdy_n, tx_rdy_n;
  int         n_chk = 0, n_fail = 0;

  dma_ready_gen u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_block_sel(dma_block_sel),
    .rx_trig_cfg(rx_trig_cfg), .tx_trig_cfg(tx_trig_cfg),
    .rx_fill(rx_fill), .tx_fill(tx_fill), .rx_timeout(rx_timeout),
    .rx_pop(rx_pop), .tx_shift_empty(tx_shift_empty),
    .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fifo_en = 1'b0; dma_block_sel = 1'b0;
    rx_trig_cfg = 8'd0; tx_trig_cfg = 8'd0; rx_fill = 8'd0; tx_fill = 8'd0;
    rx_timeout = 1'b0; rx_pop = 1'b0; tx_shift_empty = 1'b1;
    step(); step();
    chk("R1 rx during reset", rx_rdy_n, 1'b1);
    chk("R1 tx during reset", tx_rdy_n, 1'b1);
    rst_n = 1'b1;
    step();
    chk("R4 tx empty after reset", tx_rdy_n, 1'b0);
    chk("R3 rx empty after reset", rx_rdy_n, 1'b1);
  endtask

  task automatic t_single();
    rx_fill = 8'd1;
    #1;
    chk("R11 rx not yet changed", rx_rdy_n, 1'b1);
    step();
    chk("R3 rx one byte", rx_rdy_n, 1'b0);
    rx_fill = 8'd0; step();
    chk("R3 rx drained", rx_rdy_n, 1'b1);
    tx_fill = 8'd1; step();
    chk("R4 tx first byte", tx_rdy_n, 1'b1);
    tx_fill = 8'd0; tx_shift_empty = 1'b0; step();
    chk("R4 tx shifting", tx_rdy_n, 1'b1);
    tx_shift_empty = 1'b1; step();
    chk("R4 tx idle", tx_rdy_n, 1'b0);
  endtask

  task automatic t_mode_sel();
    rx_trig_cfg = 8'd8;
    fifo_en = 1'b0; dma_block_sel = 1'b1; rx_fill = 8'd1; step();
    chk("R2 fifo off acts single", rx_rdy_n, 1'b0);
    fifo_en = 1'b1; dma_block_sel = 1'b0; step();
    chk("R2 dma bit clear acts single", rx_rdy_n, 1'b0);
    rx_fill = 8'd0; step();
    dma_block_sel = 1'b1; step();
    rx_fill = 8'd1; step();
    chk("R2 block mode below threshold", rx_rdy_n, 1'b1);
    rx_fill = 8'd0; step();
  endtask

  task automatic t_rx_block();
    rx_trig_cfg = 8'd4;
    rx_fill = 8'd3; step();
    chk("R6 below threshold", rx_rdy_n, 1'b1);
    rx_fill = 8'd4; step();
    chk("R6 at threshold", rx_rdy_n, 1'b0);
    rx_fill = 8'd2; step();
    chk("R8 held while draining", rx_rdy_n, 1'b0);
    rx_fill = 8'd0; step();
    chk("R8 released on empty", rx_rdy_n, 1'b1);
    rx_fill = 8'd2; step();
    chk("R8 stays released below threshold", rx_rdy_n, 1'b1);
    rx_fill = 8'd0; step();
  endtask

  task automatic t_decode();
    rx_trig_cfg = 8'd0; rx_fill = 8'd1; step();
    chk("R5 code 0 means 1", rx_rdy_n, 1'b0);
    rx_fill = 8'd0; step();
    rx_trig_cfg = 8'd1; rx_fill = 8'd1; step();
    chk("R5 code 1 means 1", rx_rdy_n, 1'b0);
    rx_fill = 8'd0; step();
    rx_trig_cfg = 8'h80; rx_fill = 8'd127; step();
    chk("R5 code 128 at 127", rx_rdy_n, 1'b1);
    rx_fill = 8'd128; step();
    chk("R5 code 128 at 128", rx_rdy_n, 1'b0);
    rx_fill = 8'd0; step();
    rx_trig_cfg = 8'hFF; rx_fill = 8'd127; step();
    chk("R5 code 255 clamps at 127", rx_rdy_n, 1'b1);
    rx_fill = 8'd128; step();
    chk("R5 code 255 clamps at 128", rx_rdy_n, 1'b0);
    rx_fill = 8'd0; step();
  endtask

  task automatic t_timeout();
    rx_trig_cfg = 8'd16; rx_fill = 8'd2; step();
    chk("R7 below threshold before timeout", rx_rdy_n, 1'b1);
    rx_timeout = 1'b1; step();
    rx_timeout = 1'b0;
    chk("R7 timeout asserts", rx_rdy_n, 1'b0);
    rx_fill = 8'd0; rx_pop = 1'b1; step();
    rx_pop = 1'b0;
    chk("R8 drained after timeout", rx_rdy_n, 1'b1);
    rx_timeout = 1'b1; step();
    rx_timeout = 1'b0; step();
    chk("R7 timeout remembered while empty", rx_rdy_n, 1'b0);
    rx_pop = 1'b1; step();
    rx_pop = 1'b0;
    chk("R7 read clears timeout", rx_rdy_n, 1'b1);
    rx_timeout = 1'b1; rx_pop = 1'b1; step();
    rx_timeout = 1'b0; rx_pop = 1'b0; step();
    chk("R7 timeout wins over read", rx_rdy_n, 1'b0);
    rx_pop = 1'b1; step();
    rx_pop = 1'b0;
  endtask

  task automatic t_tx_block();
    tx_trig_cfg = 8'd32; tx_fill = 8'd0; step();
    chk("R9 empty requests", tx_rdy_n, 1'b0);
    tx_fill = 8'd100; step();
    chk("R10 held while filling", tx_rdy_n, 1'b0);
    tx_fill = 8'd128; step();
    chk("R10 full releases", tx_rdy_n, 1'b1);
    tx_fill = 8'd100; step();
    chk("R10 stays released, room 28", tx_rdy_n, 1'b1);
    tx_fill = 8'd96; step();
    chk("R9 room 32 requests", tx_rdy_n, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_mode_sel();
    t_rx_block();
    t_decode();
    t_timeout();
    t_tx_block();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule